// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a 32-bit physical address. It does this by walking a two-level page table that lives in ordinary memory. A requester presents the address and an access kind (read, write or execute) together with a one-cycle start strobe. The walker then reads one word from the top-level directory and one word from the second-level table it points to. It checks the valid and permission bits and reports either a physical address with a done pulse or a fault with a cause code.

When a write is allowed to a page whose dirty flag is still clear, the walker writes the updated entry back to memory, with the dirty flag set, before it reports completion. The root of the tables comes from a base register that software writes through a load strobe. Each walk uses the base value that was current when the walk was accepted.

Pages are 4 KiB. The upper ten address bits select a directory slot, the next ten bits select a table slot, and the low twelve bits pass through unchanged as the offset. Each entry is a 4-byte word, so one table of 1024 entries fills exactly one page.

Top module: `pt_walker`

## Requirements
- R1: Right after reset, `busy`, `done`, `fault` and `mem_req` are all low.
- R2: The first memory access of a walk is a read at `base + 4*vaddr[31:22]`. Here `base` is the register value at the cycle the start was accepted.
- R3: A directory word with bit 0 set leads to a read at `{pde[31:12], 12'h000} + 4*vaddr[21:12]`.
- R4: On success, `done` pulses for one cycle and `paddr` equals `{pte[31:12], vaddr[11:0]}` during that cycle.
- R5: A directory word with bit 0 (valid) clear ends the walk with `fault` and cause 1. No further memory access is made.
- R6: A table word with bit 0 (valid) clear ends the walk with `fault` and cause 2.
- R7: Access codes are 0 = read, 1 = write and 2 = execute. They need table-word bits 1, 2 and 3 respectively. A missing permission, or access code 3, ends the walk with `fault` and cause 3, and nothing is written to memory.
- R8: A permitted write whose table word has bit 4 (dirty) clear makes exactly one memory write before `done`. The write goes to the table-word address and carries the same word with bit 4 set. All other successful walks write nothing.
- R9: A start strobe raised while `busy` is high is ignored. A base-register load during a walk does not affect that walk, but it is used by the next one.
- R10: A memory request keeps `mem_req`, `mem_we` and `mem_addr` steady until the cycle in which `mem_ready` is high. `mem_rdata` is taken in that cycle.
- R11: `done` and `fault` are never high together, and each lasts one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| base_we | input | 1 | Load strobe for the table-root register |
| base_wdata | input | 32 | New table-root physical address |
| req_start | input | 1 | Start a walk (taken only when idle) |
| req_vaddr | input | 32 | Virtual address to translate |
| req_acc | input | 2 | Access kind: 0 read, 1 write, 2 execute |
| busy | output | 1 | A walk is in progress |
| mem_req | output | 1 | Memory access pending |
| mem_we | output | 1 | Pending access is a write |
| mem_addr | output | 32 | Word address of the access |
| mem_wdata | output | 32 | Write data |
| mem_ready | input | 1 | Access completes this cycle |
| mem_rdata | input | 32 | Read data, valid with `mem_ready` |
| done | output | 1 | Translation finished this cycle |
| paddr | output | 32 | Physical address, valid with `done` |
| fault | output | 1 | Walk aborted this cycle |
| fault_cause | output | 2 | 1 bad directory, 2 bad table entry, 3 permission |

## Verification
The bench builds the walker with the package defaults: 32-bit addresses split into 10, 10 and 12 bits, with 4-byte entries. This puts the real page-size arithmetic within reach, including the worked address from a directory at 0x10005000 and the all-ones corner, where both indices are 0x3FF and the offset is 0xFFF. The bench's memory model has a run-time latency that it moves between zero and three wait cycles. This exercises both the back-to-back handshake and a request held over several cycles, including a start strobe and a base load that arrive mid-walk.

// File: rtl/ptw_pkg.sv
package ptw_pkg;

    localparam int VA_W      = 32;
    localparam int PA_W      = 32;
    localparam int OFS_W     = 12;
    localparam int IDX_W     = 10;
    localparam int ENT_BYTES = 4;
    localparam int ENT_SH    = $clog2(ENT_BYTES);
    localparam int PPN_W     = PA_W - OFS_W;

    // entry flag positions
    localparam int BIT_V = 0;
    localparam int BIT_R = 1;
    localparam int BIT_W = 2;
    localparam int BIT_X = 3;
    localparam int BIT_D = 4;

    typedef enum logic [1:0] {
        ACC_READ  = 2'd0,
        ACC_WRITE = 2'd1,
        ACC_EXEC  = 2'd2,
        ACC_RSVD  = 2'd3
    } acc_e;

    typedef enum logic [1:0] {
        CAUSE_NONE = 2'd0,
        CAUSE_DIR  = 2'd1,
        CAUSE_LEAF = 2'd2,
        CAUSE_PERM = 2'd3
    } cause_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD_DIR,
        ST_RD_LEAF,
        ST_WR_LEAF,
        ST_DONE,
        ST_FAULT
    } walk_st_e;

    typedef struct packed {
        logic        ok;
        logic        valid;
        logic        mark_dirty;
        logic [PA_W-1:0] wb_word;
    } leaf_chk_t;

    function automatic logic [PA_W-1:0] slot_addr(
        input logic [PA_W-1:0]  root,
        input logic [IDX_W-1:0] idx
    );
        return root + {{(PA_W-IDX_W-ENT_SH){1'b0}}, idx, {ENT_SH{1'b0}}};
    endfunction

endpackage

// File: rtl/ptw_addr_gen.sv
module ptw_addr_gen
    import ptw_pkg::*;
(
    input  logic [VA_W-1:0]  vaddr,
    input  logic [PA_W-1:0]  root,
    input  logic [PPN_W-1:0] leaf_tbl_ppn,
    input  logic [PPN_W-1:0] page_ppn,
    output logic [PA_W-1:0]  dir_addr,
    output logic [PA_W-1:0]  leaf_addr,
    output logic [PA_W-1:0]  phys
);
    localparam int HI_LSB = OFS_W + IDX_W;

    logic [IDX_W-1:0] hi_idx;
    logic [IDX_W-1:0] lo_idx;
    logic [OFS_W-1:0] ofs;

    always_comb begin
        hi_idx    = vaddr[HI_LSB +: IDX_W];
        lo_idx    = vaddr[OFS_W +: IDX_W];
        ofs       = vaddr[OFS_W-1:0];
        dir_addr  = slot_addr(root, hi_idx);
        leaf_addr = slot_addr({leaf_tbl_ppn, {OFS_W{1'b0}}}, lo_idx);
        phys      = {page_ppn, ofs};
    end
endmodule

// File: rtl/ptw_leaf_check.sv
module ptw_leaf_check
    import ptw_pkg::*;
(
    input  logic [PA_W-1:0] word,
    input  acc_e            acc,
    output leaf_chk_t       chk
);
    logic allowed;

    always_comb begin
        unique case (acc)
            ACC_READ:  allowed = word[BIT_R];
            ACC_WRITE: allowed = word[BIT_W];
            ACC_EXEC:  allowed = word[BIT_X];
            default:   allowed = 1'b0;
        endcase
        chk.valid      = word[BIT_V];
        chk.ok         = word[BIT_V] && allowed;
        chk.mark_dirty = (acc == ACC_WRITE) && !word[BIT_D];
        chk.wb_word    = word | (PA_W'(1) << BIT_D);
    end
endmodule

// File: rtl/ptw_ctrl.sv
module ptw_ctrl
    import ptw_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [VA_W-1:0]  vaddr_in,
    input  acc_e             acc_in,
    input  logic [PA_W-1:0]  root_in,
    input  logic             mem_ready,
    input  logic [PA_W-1:0]  mem_rdata,
    input  logic [PA_W-1:0]  dir_addr,
    input  logic [PA_W-1:0]  leaf_addr,
    input  leaf_chk_t        chk,
    output logic [VA_W-1:0]  vaddr_q,
    output acc_e             acc_q,
    output logic [PA_W-1:0]  root_q,
    output logic [PPN_W-1:0] tbl_ppn_q,
    output logic [PPN_W-1:0] page_ppn_q,
    output logic             busy,
    output logic             mem_req,
    output logic             mem_we,
    output logic [PA_W-1:0]  mem_addr,
    output logic [PA_W-1:0]  mem_wdata,
    output logic             done,
    output logic             fault,
    output cause_e           cause
);
    walk_st_e        st_q;
    logic [PA_W-1:0] wb_q;
    cause_e          cause_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q       <= ST_IDLE;
            vaddr_q    <= '0;
            acc_q      <= ACC_READ;
            root_q     <= '0;
            tbl_ppn_q  <= '0;
            page_ppn_q <= '0;
            wb_q       <= '0;
            cause_q    <= CAUSE_NONE;
        end else begin
            unique case (st_q)
                ST_IDLE: if (start) begin
                    vaddr_q <= vaddr_in;
                    acc_q   <= acc_in;
                    root_q  <= root_in;
                    st_q    <= ST_RD_DIR;
                end
                ST_RD_DIR: if (mem_ready) begin
                    if (!mem_rdata[BIT_V]) begin
                        cause_q <= CAUSE_DIR;
                        st_q    <= ST_FAULT;
                    end else begin
                        tbl_ppn_q <= mem_rdata[PA_W-1:OFS_W];
                        st_q      <= ST_RD_LEAF;
                    end
                end
                ST_RD_LEAF: if (mem_ready) begin
                    page_ppn_q <= mem_rdata[PA_W-1:OFS_W];
                    wb_q       <= chk.wb_word;
                    if (!chk.valid) begin
                        cause_q <= CAUSE_LEAF;
                        st_q    <= ST_FAULT;
                    end else if (!chk.ok) begin
                        cause_q <= CAUSE_PERM;
                        st_q    <= ST_FAULT;
                    end else if (chk.mark_dirty) begin
                        st_q <= ST_WR_LEAF;
                    end else begin
                        st_q <= ST_DONE;
                    end
                end
                ST_WR_LEAF: if (mem_ready) st_q <= ST_DONE;
                ST_DONE:  st_q <= ST_IDLE;
                ST_FAULT: st_q <= ST_IDLE;
                default:  st_q <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        busy      = (st_q != ST_IDLE);
        mem_req   = (st_q == ST_RD_DIR) || (st_q == ST_RD_LEAF) || (st_q == ST_WR_LEAF);
        mem_we    = (st_q == ST_WR_LEAF);
        mem_addr  = (st_q == ST_RD_DIR) ? dir_addr : leaf_addr;
        mem_wdata = wb_q;
        done      = (st_q == ST_DONE);
        fault     = (st_q == ST_FAULT);
        cause     = cause_q;
    end
endmodule

// File: rtl/pt_walker.sv
module pt_walker
    import ptw_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        base_we,
    input  logic [31:0] base_wdata,
    input  logic        req_start,
    input  logic [31:0] req_vaddr,
    input  logic [1:0]  req_acc,
    output logic        busy,
    output logic        mem_req,
    output logic        mem_we,
    output logic [31:0] mem_addr,
    output logic [31:0] mem_wdata,
    input  logic        mem_ready,
    input  logic [31:0] mem_rdata,
    output logic        done,
    output logic [31:0] paddr,
    output logic        fault,
    output logic [1:0]  fault_cause
);
    logic [PA_W-1:0]  base_reg;
    logic [VA_W-1:0]  vaddr_q;
    acc_e             acc_q;
    logic [PA_W-1:0]  root_q;
    logic [PPN_W-1:0] tbl_ppn_q;
    logic [PPN_W-1:0] page_ppn_q;
    logic [PA_W-1:0]  dir_addr;
    logic [PA_W-1:0]  leaf_addr;
    leaf_chk_t        chk;
    cause_e           cause;

    always_ff @(posedge clk) begin
        if (rst)          base_reg <= '0;
        else if (base_we) base_reg <= base_wdata;
    end

    ptw_addr_gen u_addr (
        .vaddr        (vaddr_q),
        .root         (root_q),
        .leaf_tbl_ppn (tbl_ppn_q),
        .page_ppn     (page_ppn_q),
        .dir_addr     (dir_addr),
        .leaf_addr    (leaf_addr),
        .phys         (paddr)
    );

    ptw_leaf_check u_chk (
        .word (mem_rdata),
        .acc  (acc_q),
        .chk  (chk)
    );

    ptw_ctrl u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .start      (req_start),
        .vaddr_in   (req_vaddr),
        .acc_in     (acc_e'(req_acc)),
        .root_in    (base_reg),
        .mem_ready  (mem_ready),
        .mem_rdata  (mem_rdata),
        .dir_addr   (dir_addr),
        .leaf_addr  (leaf_addr),
        .chk        (chk),
        .vaddr_q    (vaddr_q),
        .acc_q      (acc_q),
        .root_q     (root_q),
        .tbl_ppn_q  (tbl_ppn_q),
        .page_ppn_q (page_ppn_q),
        .busy       (busy),
        .mem_req    (mem_req),
        .mem_we     (mem_we),
        .mem_addr   (mem_addr),
        .mem_wdata  (mem_wdata),
        .done       (done),
        .fault      (fault),
        .cause      (cause)
    );

    assign fault_cause = cause;
endmodule

// File: rtl/pt_walker_chk.sv
module pt_walker_chk (
    input logic        clk,
    input logic        rst,
    input logic        busy,
    input logic        mem_req,
    input logic        mem_we,
    input logic [31:0] mem_addr,
    input logic [31:0] mem_wdata,
    input logic        mem_ready,
    input logic        done,
    input logic        fault,
    input logic [1:0]  fault_cause
);
    AST_NO_MEM_WHEN_IDLE: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !mem_req); // R1
    AST_WB_SETS_DIRTY: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_we) |-> mem_wdata[4]); // R8
    AST_REQ_HELD: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr) && $stable(mem_we))); // R10
    AST_DONE_FAULT_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(done && fault)); // R11
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R11
    AST_FAULT_PULSE: assert property (@(posedge clk) disable iff (rst)
        fault |=> !fault); // R11
    AST_FAULT_HAS_CAUSE: assert property (@(posedge clk) disable iff (rst)
        fault |-> (fault_cause != 2'd0)); // R5
endmodule

bind pt_walker pt_walker_chk u_pt_walker_chk (
    .clk         (clk),
    .rst         (rst),
    .busy        (busy),
    .mem_req     (mem_req),
    .mem_we      (mem_we),
    .mem_addr    (mem_addr),
    .mem_wdata   (mem_wdata),
    .mem_ready   (mem_ready),
    .done        (done),
    .fault       (fault),
    .fault_cause (fault_cause)
);

// File: tb/pt_walker_tb.sv
module pt_walker_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        base_we = 1'b0;
    logic [31:0] base_wdata = '0;
    logic        req_start = 1'b0;
    logic [31:0] req_vaddr = '0;
    logic [1:0]  req_acc = '0;
    logic        busy, mem_req, mem_we, done, fault;
    logic [31:0] mem_addr, mem_wdata, paddr;
    logic        mem_ready = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic [1:0]  fault_cause;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    pt_walker u_dut (
        .clk(clk), .rst(rst), .base_we(base_we), .base_wdata(base_wdata),
        .req_start(req_start), .req_vaddr(req_vaddr), .req_acc(req_acc),
        .busy(busy), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_ready(mem_ready), .mem_rdata(mem_rdata),
        .done(done), .paddr(paddr), .fault(fault), .fault_cause(fault_cause)
    );

    // memory model with adjustable wait cycles
    logic [31:0] mem [logic [31:0]];
    int          lat = 0;
    int          wcnt = 0;
    int          rd_cnt = 0;
    int          wr_cnt = 0;
    logic [31:0] rd_log [4];
    logic [31:0] wr_addr_log;
    logic [31:0] wr_data_log;

    always @(posedge clk) begin
        if (mem_req && !mem_ready) begin
            if (wcnt >= lat) begin
                wcnt <= 0;
                mem_ready <= 1'b1;
                if (mem_we) begin
                    mem[mem_addr] = mem_wdata;
                    wr_addr_log <= mem_addr;
                    wr_data_log <= mem_wdata;
                    wr_cnt <= wr_cnt + 1;
                end else begin
                    mem_rdata <= mem.exists(mem_addr) ? mem[mem_addr] : 32'h0;
                    if (rd_cnt < 4) rd_log[rd_cnt] <= mem_addr;
                    rd_cnt <= rd_cnt + 1;
                end
            end else begin
                wcnt <= wcnt + 1;
            end
        end else begin
            mem_ready <= 1'b0;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    logic        r_done, r_fault;
    logic [31:0] r_paddr;
    logic [1:0]  r_cause;

    task automatic clear_logs();
        @(negedge clk);
        rd_cnt = 0; wr_cnt = 0;
        for (int i = 0; i < 4; i++) rd_log[i] = '0;
    endtask

    task automatic wait_end();
        r_done = 0; r_fault = 0;
        for (int i = 0; i < 200; i++) begin
            if (done || fault) break;
            @(negedge clk);
        end
        r_done = done; r_fault = fault; r_paddr = paddr; r_cause = fault_cause;
        @(negedge clk);
    endtask

    task automatic walk(input logic [31:0] va, input logic [1:0] ac);
        clear_logs();
        req_vaddr = va; req_acc = ac; req_start = 1'b1;
        @(negedge clk);
        req_start = 1'b0;
        wait_end();
    endtask

    task automatic set_base(input logic [31:0] b);
        @(negedge clk);
        base_we = 1'b1; base_wdata = b;
        @(negedge clk);
        base_we = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1 busy", {31'b0, busy}, 32'd0);
        chk("R1 done", {31'b0, done}, 32'd0);
        chk("R1 fault", {31'b0, fault}, 32'd0);
        chk("R1 mem_req", {31'b0, mem_req}, 32'd0);
    endtask

    task automatic t_dirty_write();
        lat = 1;
        walk(32'h7192A44C, 2'd1);
        chk("R2 dir read addr", rd_log[0], 32'h10005718);
        chk("R3 leaf read addr", rd_log[1], 32'h123454A8);
        chk("R4 done", {31'b0, r_done}, 32'd1);
        chk("R4 paddr", r_paddr, 32'h1481744C);
        chk("R8 one write", wr_cnt, 32'd1);
        chk("R8 write addr", wr_addr_log, 32'h123454A8);
        chk("R8 mem after", mem[32'h123454A8], 32'h14817017);
        // entry now dirty: second write stores nothing
        walk(32'h7192A000, 2'd1);
        chk("R8 no rewrite", wr_cnt, 32'd0);
        chk("R4 paddr dirty", r_paddr, 32'h14817000);
    endtask

    task automatic t_read_exec();
        lat = 0;
        walk(32'h7192B000, 2'd0);
        chk("R4 read paddr", r_paddr, 32'h0AAAA000);
        chk("R8 read writes", wr_cnt, 32'd0);
        walk(32'h7192C010, 2'd2);
        chk("R4 exec paddr", r_paddr, 32'h0BBBB010);
        chk("R7 exec ok no fault", {31'b0, r_fault}, 32'd0);
        walk(32'h7192E123, 2'd1);
        chk("R4 dirty page paddr", r_paddr, 32'h0DDDD123);
        chk("R8 dirty page no write", wr_cnt, 32'd0);
    endtask

    task automatic t_faults();
        lat = 2;
        walk(32'h00400000, 2'd0);
        chk("R5 fault", {31'b0, r_fault}, 32'd1);
        chk("R5 cause", {30'b0, r_cause}, 32'd1);
        chk("R5 single read", rd_cnt, 32'd1);
        chk("R5 dir addr", rd_log[0], 32'h10005004);
        walk(32'h7192D000, 2'd0);
        chk("R6 fault", {31'b0, r_fault}, 32'd1);
        chk("R6 cause", {30'b0, r_cause}, 32'd2);
        chk("R6 reads", rd_cnt, 32'd2);
        walk(32'h7192B000, 2'd1);
        chk("R7 write ro cause", {30'b0, r_cause}, 32'd3);
        chk("R7 write ro no write", wr_cnt, 32'd0);
        chk("R7 entry unchanged", mem[32'h123454AC], 32'h0AAAA003);
        walk(32'h7192B000, 2'd2);
        chk("R7 exec ro cause", {30'b0, r_cause}, 32'd3);
        walk(32'h7192B000, 2'd3);
        chk("R7 code3 cause", {30'b0, r_cause}, 32'd3);
        chk("R11 no done on fault", {31'b0, r_done}, 32'd0);
    endtask

    task automatic t_midwalk();
        lat = 3;
        clear_logs();
        req_vaddr = 32'h7192A44C; req_acc = 2'd0; req_start = 1'b1;
        @(negedge clk);
        req_start = 1'b0;
        @(negedge clk);
        req_vaddr = 32'h00400000; req_start = 1'b1;
        base_we = 1'b1; base_wdata = 32'h00200000;
        @(negedge clk);
        req_start = 1'b0; base_we = 1'b0;
        wait_end();
        chk("R9 done", {31'b0, r_done}, 32'd1);
        chk("R9 paddr old walk", r_paddr, 32'h1481744C);
        chk("R9 old base used", rd_log[0], 32'h10005718);
        repeat (6) @(negedge clk);
        chk("R9 stays idle", {31'b0, busy}, 32'd0);
        chk("R9 no extra reads", rd_cnt, 32'd2);
        // next walk uses the new base, all-ones corner
        lat = 0;
        walk(32'hFFFFFFFF, 2'd0);
        chk("R2 new base dir addr", rd_log[0], 32'h00200FFC);
        chk("R3 top leaf addr", rd_log[1], 32'h00300FFC);
        chk("R4 top paddr", r_paddr, 32'h000FFFFF);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        mem[32'h10005718] = 32'h12345001;
        mem[32'h123454A8] = 32'h14817007;
        mem[32'h123454AC] = 32'h0AAAA003;
        mem[32'h123454B0] = 32'h0BBBB009;
        mem[32'h123454B4] = 32'h0CCCC006;
        mem[32'h123454B8] = 32'h0DDDD017;
        mem[32'h10005004] = 32'h22222000;
        mem[32'h00200FFC] = 32'h00300001;
        mem[32'h00300FFC] = 32'h000FF00F;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        set_base(32'h10005000);
        t_dirty_write();
        t_read_exec();
        t_faults();
        t_midwalk();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule